// File: doc/BRIEF.md
# Capture/Compare Counter Array

The block runs one 16-bit counter and shares it among five channels. Each channel holds a 16-bit value register and a 7-bit mode register. Depending on the mode, a channel can do one of four jobs:

- latch the count on a pin edge;
- raise a flag when the count reaches a target;
- toggle its pin on that match;
- produce an 8-bit pulse-width signal from the counter's low byte.

The last channel can also drive a watchdog reset pulse on a match. Software must therefore keep moving that channel's target ahead of the counter.

Software reaches every register through a single-cycle write strobe with a byte-wide address and data. Reads are combinational from the address. The counter's tick comes from one of four sources: every clock, two internal divided rates, or the rising edges of an external count pin. The external pin is synchronised, so its rate is bounded by the clock.

Top module: `ccp_array`

## Requirements
- R1: After synchronous reset the counter, all registers and flags are zero; `cex_o`, `cex_oe_o`, `ch_flag_o`, `ovf_flag_o`, `irq_o` and `wdog_rst_o` are low.
- R2: While the run bit is set, the counter adds one per tick. Clock-select field CFG[1:0] picks the tick source:
  - 0: every clock;
  - 1: every 4th clock;
  - 2: every 16th clock;
  - 3: each rising edge of `ext_count_i`, after a two-flop synchroniser and a further edge register.

  With the run bit clear the counter holds. A divider counts clocks only while the run bit is set. A write to a counter byte replaces that byte and suppresses the tick in that cycle.
- R3: When a tick moves the counter from 0xFFFF to 0x0000, the overflow flag is set. With CFG[2] set, the overflow flag drives `irq_o`.
- R4: The register map is as follows:
  - 0x00 CTRL: [4:0] channel flags, [6] run, [7] overflow flag.
  - 0x01 CFG: [1:0] clock select, [2] overflow interrupt enable, [3] watchdog enable.
  - 0x02 and 0x03: counter low and high byte.
  - Channel n at 0x08+4n: +0 mode, +1 value low byte, +2 value high byte.
  - Unmapped addresses read 0.

  Writing CTRL loads all its fields. A hardware flag set in the same cycle wins over a software clear.
- R5: The mode bits are:
  - [0] compare enable
  - [1] capture on rising edge
  - [2] capture on falling edge
  - [3] match enable
  - [4] toggle enable
  - [5] PWM enable
  - [6] flag interrupt enable

  `cex_oe_o[n]` is high when compare is enabled and neither capture bit is set.
- R6: With compare and match enabled, a tick that moves the counter onto the channel's 16-bit value sets the channel flag. The flag appears in the same cycle the counter shows that value.
- R7: If toggle is also enabled, that match inverts the channel's output level.
- R8: With compare and PWM enabled, `cex_o[n]` is high exactly when counter[7:0] >= the value low byte. Otherwise `cex_o[n]` shows the toggle level.
- R9: In PWM mode, each tick that takes counter[7:0] from 0xFF to 0x00 copies the value high byte into the low byte.
- R10: A selected edge of the synchronised `cex_i[n]` copies the 16-bit count into the value register and sets the channel flag. This happens three clock edges after the pin changes.
- R11: Writing a value low byte clears that channel's compare enable. Writing the high byte sets it.
- R12: With CFG[3] set, a match on channel 4 gives a one-cycle `wdog_rst_o` pulse in the cycle its flag rises.
- R13: `irq_o` is the OR of each channel flag gated by its interrupt enable, together with the gated overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ext_count_i | input | 1 | External count pin |
| cex_i | input | 5 | Channel pins as inputs (capture) |
| cex_o | output | 5 | Channel output levels |
| cex_oe_o | output | 5 | Channel output enables |
| ch_flag_o | output | 5 | Channel event flags |
| ovf_flag_o | output | 1 | Counter overflow flag |
| irq_o | output | 1 | Combined interrupt |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A behavioural model runs alongside the design and is compared on every clock against all outputs and the read port.

The bench drives the design through several patterns:

- Each of the four tick sources is run in turn. Increment counts over fixed windows separate the divided rates from each other and from the pin-driven rate.
- A PWM channel has its high byte changed mid-period. Its duty count over a full period after reload shows whether the reload happens at low-byte wrap or immediately.
- Capture on both edges, a toggling match, a plain timer match, a forced wrap and a watchdog match each give distinct flag and pin traces.
- Split byte writes are checked for their effect on the compare enable.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int NUM_CH    = 5;
    localparam int CNT_W     = 16;
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 4;

    typedef enum logic [1:0] {
        TICK_EVERY = 2'd0,
        TICK_DIV_A = 2'd1,
        TICK_DIV_B = 2'd2,
        TICK_PIN   = 2'd3
    } tick_sel_e;

    // bit 0 is cmp_en ... bit 6 is irq_en
    typedef struct packed {
        logic irq_en;
        logic pwm_en;
        logic toggle_en;
        logic match_en;
        logic cap_fall;
        logic cap_rise;
        logic cmp_en;
    } ch_mode_t;

    localparam logic [4:0] A_CTRL   = 5'h00;
    localparam logic [4:0] A_CFG    = 5'h01;
    localparam logic [4:0] A_CNT_LO = 5'h02;
    localparam logic [4:0] A_CNT_HI = 5'h03;

    function automatic logic [4:0] ch_addr(input int ch, input int off);
        return 5'(CH_BASE + CH_STRIDE * ch + off);
    endfunction

endpackage

// File: rtl/ccp_timebase.sv
module ccp_timebase
    import ccp_pkg::*;
#(
    parameter int DIV_A_LOG2 = 2,
    parameter int DIV_B_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  tick_sel_e        sel_i,
    input  logic             ext_pin_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             step_o
);

    localparam int DIV_W = DIV_B_LOG2;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       pin_sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             pin_rise;

    assign pin_rise = pin_sync_q[1] & ~pin_sync_q[2];

    always_comb begin
        case (sel_i)
            TICK_EVERY: tick = 1'b1;
            TICK_DIV_A: tick = &div_q[DIV_A_LOG2-1:0];
            TICK_DIV_B: tick = &div_q;
            default:    tick = pin_rise;
        endcase
    end

    assign step_o = run_i & tick & ~(wr_lo_i | wr_hi_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= '0;
            pin_sync_q <= '0;
            cnt_q      <= '0;
        end else begin
            pin_sync_q <= {pin_sync_q[1:0], ext_pin_i};
            if (run_i) div_q <= div_q + 1'b1;
            if (wr_lo_i || wr_hi_i) begin
                if (wr_lo_i) cnt_q[7:0]  <= wdata_i;
                if (wr_hi_i) cnt_q[15:8] <= wdata_i;
            end else if (step_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step_o |=> cnt_q == $past(cnt_q) + 16'd1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr_i,
    input  ch_mode_t         mode_wdata_i,
    input  logic             lo_wr_i,
    input  logic             hi_wr_i,
    input  logic [7:0]       wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             step_i,
    input  logic             cex_i,
    output ch_mode_t         mode_o,
    output logic [CNT_W-1:0] val_o,
    output logic             hit_o,
    output logic             flag_set_o,
    output logic             cex_o,
    output logic             cex_oe_o
);

    ch_mode_t         mode_q;
    logic [7:0]       lo_q;
    logic [7:0]       hi_q;
    logic             tog_q;
    logic [2:0]       pin_sync_q;
    logic [CNT_W-1:0] cnt_next;
    logic             reload;
    logic             cap_evt;
    logic             pwm_on;

    assign cnt_next = cnt_i + 16'd1;
    assign pwm_on   = mode_q.cmp_en & mode_q.pwm_en;
    assign hit_o    = mode_q.cmp_en & mode_q.match_en & step_i & (cnt_next == {hi_q, lo_q});
    assign reload   = pwm_on & step_i & (cnt_i[7:0] == 8'hFF);
    assign cap_evt  = (mode_q.cap_rise &  pin_sync_q[1] & ~pin_sync_q[2])
                    | (mode_q.cap_fall & ~pin_sync_q[1] &  pin_sync_q[2]);

    assign flag_set_o = hit_o | cap_evt;
    assign cex_o      = pwm_on ? (cnt_i[7:0] >= lo_q) : tog_q;
    assign cex_oe_o   = mode_q.cmp_en & ~(mode_q.cap_rise | mode_q.cap_fall);
    assign mode_o     = mode_q;
    assign val_o      = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            tog_q      <= 1'b0;
            pin_sync_q <= '0;
        end else begin
            pin_sync_q <= {pin_sync_q[1:0], cex_i};
            if (mode_wr_i)    mode_q        <= mode_wdata_i;
            else if (lo_wr_i) mode_q.cmp_en <= 1'b0;
            else if (hi_wr_i) mode_q.cmp_en <= 1'b1;
            if (reload)  lo_q <= hi_q;
            if (lo_wr_i) lo_q <= wdata_i;
            if (hi_wr_i) hi_q <= wdata_i;
            if (cap_evt) begin
                lo_q <= cnt_i[7:0];
                hi_q <= cnt_i[15:8];
            end
            if (hit_o && mode_q.toggle_en) tog_q <= ~tog_q;
        end
    end

    AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (hit_o && mode_q.toggle_en) |=> tog_q != $past(tog_q)); // R7
    AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (reload && !lo_wr_i && !cap_evt) |=> lo_q == $past(hi_q)); // R9
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> {hi_q, lo_q} == $past(cnt_i)); // R10
    AST_ATOMIC_LO: assert property (@(posedge clk) disable iff (rst)
        (lo_wr_i && !mode_wr_i) |=> !mode_q.cmp_en); // R11

endmodule

// File: rtl/ccp_array.sv
module ccp_array
    import ccp_pkg::*;
#(
    parameter int DIV_A_LOG2 = 2,
    parameter int DIV_B_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic [4:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              ext_count_i,
    input  logic [NUM_CH-1:0] cex_i,
    output logic [NUM_CH-1:0] cex_o,
    output logic [NUM_CH-1:0] cex_oe_o,
    output logic [NUM_CH-1:0] ch_flag_o,
    output logic              ovf_flag_o,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    localparam int WD_CH = NUM_CH - 1;

    logic              run_q, ovf_q, ovf_ie_q, wd_en_q, wdog_q;
    logic [1:0]        sel_q;
    logic [NUM_CH-1:0] flag_q;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    logic              ovf_set;
    logic              wr_ctrl, wr_cfg, wr_cnt_lo, wr_cnt_hi;
    ch_mode_t          mode_arr [NUM_CH];
    logic [CNT_W-1:0]  val_arr  [NUM_CH];
    logic [NUM_CH-1:0] hit_vec, flag_set_vec, irq_en_vec;

    assign wr_ctrl   = bus_wr_i && (bus_addr_i == A_CTRL);
    assign wr_cfg    = bus_wr_i && (bus_addr_i == A_CFG);
    assign wr_cnt_lo = bus_wr_i && (bus_addr_i == A_CNT_LO);
    assign wr_cnt_hi = bus_wr_i && (bus_addr_i == A_CNT_HI);

    ccp_timebase #(
        .DIV_A_LOG2(DIV_A_LOG2),
        .DIV_B_LOG2(DIV_B_LOG2)
    ) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_q),
        .sel_i     (tick_sel_e'(sel_q)),
        .ext_pin_i (ext_count_i),
        .wr_lo_i   (wr_cnt_lo),
        .wr_hi_i   (wr_cnt_hi),
        .wdata_i   (bus_wdata_i),
        .cnt_o     (cnt),
        .step_o    (step)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ccp_channel u_ch (
            .clk          (clk),
            .rst          (rst),
            .mode_wr_i    (bus_wr_i && (bus_addr_i == ch_addr(g, 0))),
            .mode_wdata_i (ch_mode_t'(bus_wdata_i[6:0])),
            .lo_wr_i      (bus_wr_i && (bus_addr_i == ch_addr(g, 1))),
            .hi_wr_i      (bus_wr_i && (bus_addr_i == ch_addr(g, 2))),
            .wdata_i      (bus_wdata_i),
            .cnt_i        (cnt),
            .step_i       (step),
            .cex_i        (cex_i[g]),
            .mode_o       (mode_arr[g]),
            .val_o        (val_arr[g]),
            .hit_o        (hit_vec[g]),
            .flag_set_o   (flag_set_vec[g]),
            .cex_o        (cex_o[g]),
            .cex_oe_o     (cex_oe_o[g])
        );
        assign irq_en_vec[g] = mode_arr[g].irq_en;
    end

    assign ovf_set = step && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            ovf_q    <= 1'b0;
            flag_q   <= '0;
            sel_q    <= '0;
            ovf_ie_q <= 1'b0;
            wd_en_q  <= 1'b0;
            wdog_q   <= 1'b0;
        end else begin
            flag_q <= (wr_ctrl ? bus_wdata_i[NUM_CH-1:0] : flag_q) | flag_set_vec;
            ovf_q  <= (wr_ctrl ? bus_wdata_i[7] : ovf_q) | ovf_set;
            if (wr_ctrl) run_q <= bus_wdata_i[6];
            if (wr_cfg) begin
                sel_q    <= bus_wdata_i[1:0];
                ovf_ie_q <= bus_wdata_i[2];
                wd_en_q  <= bus_wdata_i[3];
            end
            wdog_q <= wd_en_q & hit_vec[WD_CH];
        end
    end

    assign ch_flag_o  = flag_q;
    assign ovf_flag_o = ovf_q;
    assign wdog_rst_o = wdog_q;
    assign irq_o      = (|(flag_q & irq_en_vec)) | (ovf_q & ovf_ie_q);

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL:   bus_rdata_o = {ovf_q, run_q, 1'b0, flag_q};
            A_CFG:    bus_rdata_o = {4'b0, wd_en_q, ovf_ie_q, sel_q};
            A_CNT_LO: bus_rdata_o = cnt[7:0];
            A_CNT_HI: bus_rdata_o = cnt[15:8];
            default:  bus_rdata_o = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == ch_addr(i, 0)) bus_rdata_o = {1'b0, mode_arr[i]};
            if (bus_addr_i == ch_addr(i, 1)) bus_rdata_o = val_arr[i][7:0];
            if (bus_addr_i == ch_addr(i, 2)) bus_rdata_o = val_arr[i][15:8];
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_q); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R4
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        hit_vec[0] |=> flag_q[0]); // R6
    AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wd_en_q && hit_vec[WD_CH]) |=> wdog_rst_o); // R12

endmodule

// File: tb/ccp_array_tb_top.sv
module ccp_array_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = 5'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic [4:0] cex_in = 5'd0;
    logic [4:0] cex_out, cex_oe, ch_flag;
    logic       ovf_flag, irq, wdog;

    always #4 clk = ~clk;

    ccp_array dut_i (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ext_count_i(ext_pin),
        .cex_i(cex_in), .cex_o(cex_out), .cex_oe_o(cex_oe), .ch_flag_o(ch_flag),
        .ovf_flag_o(ovf_flag), .irq_o(irq), .wdog_rst_o(wdog)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int wd_pulses = 0;

    // behavioural model state
    int       m_cnt, m_div, m_sel;
    bit       m_run, m_ovf, m_ovfie, m_wden, m_wd;
    bit [4:0] m_flag;
    bit [6:0] m_mode [5];
    int       m_lo [5];
    int       m_hi [5];
    bit       m_tog [5];
    bit [2:0] m_cs [5];
    bit [2:0] m_es;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_div = 0; m_sel = 0;
        m_run = 0; m_ovf = 0; m_ovfie = 0; m_wden = 0; m_wd = 0;
        m_flag = 0; m_es = 0;
        for (int c = 0; c < 5; c++) begin
            m_mode[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_tog[c] = 0; m_cs[c] = 0;
        end
    endtask

    task automatic model_step();
        bit tick, cwr, step, ovs, hit4, cmpb, rise, fall, hit, rl, cap;
        bit [4:0] fset;
        int base;
        case (m_sel)
            0: tick = 1;
            1: tick = (m_div % 4) == 3;
            2: tick = m_div == 15;
            default: tick = m_es[1] && !m_es[2];
        endcase
        cwr  = bus_wr && (bus_addr == 5'd2 || bus_addr == 5'd3);
        step = m_run && tick && !cwr;
        ovs  = step && m_cnt == 65535;
        fset = 0;
        hit4 = 0;
        for (int c = 0; c < 5; c++) begin
            base = 8 + 4 * c;
            cmpb = m_mode[c][0];
            rise = m_mode[c][1];
            fall = m_mode[c][2];
            hit  = cmpb && m_mode[c][3] && step && (((m_cnt + 1) % 65536) == m_hi[c] * 256 + m_lo[c]);
            rl   = cmpb && m_mode[c][5] && step && (m_cnt % 256 == 255);
            cap  = (rise && m_cs[c][1] && !m_cs[c][2]) || (fall && !m_cs[c][1] && m_cs[c][2]);
            if (hit || cap) fset[c] = 1;
            if (c == 4) hit4 = hit;
            if (rl) m_lo[c] = m_hi[c];
            if (bus_wr && bus_addr == 5'(base + 1)) m_lo[c] = bus_wdata;
            if (bus_wr && bus_addr == 5'(base + 2)) m_hi[c] = bus_wdata;
            if (cap) begin
                m_lo[c] = m_cnt % 256;
                m_hi[c] = m_cnt / 256;
            end
            if (bus_wr && bus_addr == 5'(base)) m_mode[c] = bus_wdata[6:0];
            else if (bus_wr && bus_addr == 5'(base + 1)) m_mode[c][0] = 0;
            else if (bus_wr && bus_addr == 5'(base + 2)) m_mode[c][0] = 1;
            if (hit && m_mode[c][4]) m_tog[c] = !m_tog[c];
            m_cs[c] = {m_cs[c][1:0], cex_in[c]};
        end
        m_wd = m_wden && hit4;
        if (m_run) m_div = (m_div + 1) % 16;
        if (bus_wr && bus_addr == 5'd2) m_cnt = (m_cnt & 32'hFF00) | bus_wdata;
        else if (bus_wr && bus_addr == 5'd3) m_cnt = (m_cnt & 32'h00FF) | (int'(bus_wdata) << 8);
        else if (step) m_cnt = (m_cnt + 1) % 65536;
        if (bus_wr && bus_addr == 5'd0) begin
            m_flag = bus_wdata[4:0];
            m_ovf  = bus_wdata[7];
            m_run  = bus_wdata[6];
        end
        m_flag = m_flag | fset;
        m_ovf  = m_ovf | ovs;
        if (bus_wr && bus_addr == 5'd1) begin
            m_sel   = bus_wdata[1:0];
            m_ovfie = bus_wdata[2];
            m_wden  = bus_wdata[3];
        end
        m_es = {m_es[1:0], ext_pin};
    endtask

    function automatic int model_read(input int a);
        int c, o;
        if (a == 0) return {m_ovf, m_run, 1'b0, m_flag};
        if (a == 1) return {m_wden, m_ovfie, 2'(m_sel)};
        if (a == 2) return m_cnt % 256;
        if (a == 3) return m_cnt / 256;
        if (a >= 8 && a < 28) begin
            c = (a - 8) / 4;
            o = (a - 8) % 4;
            if (o == 0) return int'(m_mode[c]);
            if (o == 1) return m_lo[c];
            if (o == 2) return m_hi[c];
        end
        return 0;
    endfunction

    function automatic bit m_cex(input int c);
        if (m_mode[c][0] && m_mode[c][5]) return (m_cnt % 256) >= m_lo[c];
        return m_tog[c];
    endfunction

    function automatic bit m_irq();
        bit r;
        r = m_ovf && m_ovfie;
        for (int c = 0; c < 5; c++) if (m_flag[c] && m_mode[c][6]) r = 1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (wdog) wd_pulses++;
            for (int c = 0; c < 5; c++) begin
                check($sformatf("R7 R8 cex_o[%0d]", c), int'(cex_out[c]), int'(m_cex(c)));
                check($sformatf("R5 cex_oe_o[%0d]", c), int'(cex_oe[c]),
                      int'(m_mode[c][0] && !(m_mode[c][1] || m_mode[c][2])));
            end
            check("R6 R10 ch_flag_o", int'(ch_flag), int'(m_flag));
            check("R3 ovf_flag_o", int'(ovf_flag), int'(m_ovf));
            check("R13 irq_o", int'(irq), int'(m_irq()));
            check("R12 wdog_rst_o", int'(wdog), int'(m_wd));
            check("R4 read data", int'(bus_rdata), model_read(int'(bus_addr)));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_at(input logic [4:0] a);
        @(negedge clk);
        bus_addr = a;
        #2;
    endtask

    task automatic set_target(input int ch, input int t);
        wr(5'(9 + 4 * ch), 8'(t % 256));
        wr(5'(10 + 4 * ch), 8'(t / 256));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a0, a1, t, highs;
        idle(4);
        rst = 1'b0;
        rd_at(5'd0);
        // R1: reset state
        check("R1 ctrl after reset", int'(bus_rdata), 0);
        check("R1 outputs after reset", int'({cex_out, cex_oe, ch_flag, ovf_flag, irq, wdog}), 0);

        // R2: run every clock
        wr(5'd1, 8'h00);
        wr(5'd0, 8'h40);
        rd_at(5'd2);
        a0 = bus_rdata;
        idle(10);
        #2;
        check("R2 every-clock rate", (int'(bus_rdata) - a0 + 256) % 256, 10);

        // R6/R13: software timer with interrupt on ch0
        wr(5'd8, 8'h49);
        t = (m_cnt + 30) % 65536;
        set_target(0, t);
        idle(40);
        check("R6 timer flag", int'(ch_flag[0]), 1);
        check("R13 irq from ch0", int'(irq), 1);
        wr(5'd0, 8'h40);

        // R11: split write gating of compare enable
        wr(5'd9, 8'h00);
        rd_at(5'd8);
        check("R11 lo write clears compare", int'(bus_rdata[0]), 0);
        wr(5'd10, 8'h00);
        rd_at(5'd8);
        check("R11 hi write sets compare", int'(bus_rdata[0]), 1);

        // R7: toggle on match, ch1
        wr(5'd12, 8'h19);
        t = (m_cnt + 25) % 65536;
        set_target(1, t);
        idle(30);
        check("R7 toggled level", int'(cex_out[1]), 1);

        // R8/R9: PWM on ch2, duty reloaded from high byte at wrap
        wr(5'd16, 8'h21);
        wr(5'd17, 8'h40);
        wr(5'd18, 8'hC0);
        wr(5'd16, 8'h21);
        idle(600);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            #2;
            if (cex_out[2]) highs++;
        end
        check("R8 R9 duty after reload", highs, 64);

        // R10: capture on both edges, ch3
        wr(5'd20, 8'h06);
        idle(3);
        @(negedge clk); cex_in[3] = 1'b1;
        idle(6);
        check("R10 rising capture flag", int'(ch_flag[3]), 1);
        wr(5'd0, 8'h40);
        @(negedge clk); cex_in[3] = 1'b0;
        idle(6);
        check("R10 falling capture flag", int'(ch_flag[3]), 1);
        rd_at(5'd21);
        check("R10 captured low byte", int'(bus_rdata), model_read(21));

        // R2: divided rates and external pin
        wr(5'd1, 8'h01);
        rd_at(5'd2);
        a0 = bus_rdata;
        idle(40);
        #2;
        check("R2 divide-by-4 rate", (int'(bus_rdata) - a0 + 256) % 256, 10);
        wr(5'd1, 8'h02);
        rd_at(5'd2);
        a0 = bus_rdata;
        idle(64);
        #2;
        check("R2 divide-by-16 rate", (int'(bus_rdata) - a0 + 256) % 256, 4);
        wr(5'd1, 8'h03);
        rd_at(5'd2);
        a0 = bus_rdata;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ext_pin = 1'b1;
            idle(3);
            @(negedge clk); ext_pin = 1'b0;
            idle(3);
        end
        idle(4);
        #2;
        check("R2 external pin count", (int'(bus_rdata) - a0 + 256) % 256, 8);

        // R3: overflow with interrupt enabled
        wr(5'd1, 8'h04);
        wr(5'd3, 8'hFF);
        wr(5'd2, 8'hF0);
        idle(30);
        check("R3 overflow flag", int'(ovf_flag), 1);
        check("R3 overflow irq", int'(irq), 1);
        wr(5'd0, 8'h40);

        // R12: watchdog on ch4
        wr(5'd1, 8'h08);
        wr(5'd24, 8'h09);
        t = (m_cnt + 40) % 65536;
        set_target(4, t);
        a1 = wd_pulses;
        idle(60);
        check("R12 watchdog pulses", wd_pulses - a1, 1);

        // R2: halt holds the counter
        wr(5'd0, 8'h00);
        rd_at(5'd2);
        a0 = bus_rdata;
        idle(20);
        #2;
        check("R2 halted counter", int'(bus_rdata), a0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule